// File: doc/BRIEF.md
# Posted-Write SRAM Controller

This block sits between a simple request/ready bus and a byte-addressed, single-port synchronous SRAM that it contains. Every accepted write is parked in a one-entry posted buffer instead of going to the array. The parked write reaches the array only when the next write is accepted. The array port is used for that commit in the same cycle, and the new write takes the buffer's place. Writes therefore never wait for the array, and back-to-back writes flow at one per cycle.

Accesses are byte, halfword or word sized. Wider accesses are forced onto their natural boundary. Write data is lane-aligned: a byte at offset k travels on bits [8k+7:8k]. A read whose word matches the parked entry gets the parked byte lanes merged over the array word.

Because the parked entry is volatile, a reset loses the most recent write. Software that needs the data to survive can issue the same write twice, or follow it with any dummy write.

Top module: `pwb_sram_ctrl`

## Requirements
- R1: `size_i` selects the access width: 0 is byte, 1 is halfword, 2 is word, and the reserved code 3 behaves as word. Byte lane k of a word carries the byte at address offset k on `wdata_i[8k+7:8k]` and `rdata_o[8k+7:8k]`.
- R2: A halfword access ignores address bit 0 and a word access ignores address bits 1:0, so both always touch the naturally aligned bytes.
- R3: An accepted write is held in the posted buffer and is not placed in the array by that write itself.
- R4: Accepting a write while the buffer is valid commits the buffered entry to the array in that cycle, and the new write becomes the buffered entry.
- R5: An active-low reset clears the buffer-valid flag without committing the entry, so after reset the array lacks the last write. The array itself keeps its contents through reset.
- R6: Two identical consecutive writes leave the data in the array, where it survives a following reset.
- R7: `ready_o` is low while reset is asserted, rises on the first clock after release, and then stays high, so back-to-back writes are accepted every cycle without a stall.
- R8: A read of the word held in the buffer returns the buffered lanes merged over the array data. The merge uses the buffer contents at the cycle the read is accepted, even if a write replaces the buffer in the very next cycle.
- R9: A commit writes only the byte lanes of the buffered write, and leaves the other bytes of that array word unchanged.
- R10: Read data appears on `rdata_o` with `rvalid_o` high for exactly one cycle, in the cycle after the read is accepted. `rvalid_o` is low in reset and in every cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access width code |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Lane-aligned write data |
| ready_o | output | 1 | Request accepted when high |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Aligned read word |

## Verification
The bench targets a write that is reset while still parked. A design that wrote through at once would return the new data instead of the old array value. Doubled writes and dummy-write flushes are then reset and read back; a design that dropped the commit, or committed a stale entry, would lose them.

A byte write is followed by a commit and then a reset, to expose a commit that rewrites whole words. Misaligned halfword and word addresses expose sizes that do not honour natural alignment. A read followed at once by a write to the same word exposes forwarding that samples the buffer a cycle late.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/pwb_lane_decode.sv
module pwb_lane_decode #(
  parameter int NB    = 4,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [NB-1:0]    be_o
);
  import pwb_pkg::*;

  int unsigned nbytes;
  int unsigned base;

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = (NB >= 2) ? 2 : NB;
      default: nbytes = NB;
    endcase
    // natural alignment: clear offset bits below the access width
    base = int'(off_i) & ~(nbytes - 1);
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign be_o[b] = (b >= base) && (b < base + nbytes);
  end
endmodule

// File: rtl/pwb_sram_model.sv
module pwb_sram_model #(
  parameter int WORDS  = 1024,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [NB-1:0]     be_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (be_i[b]) mem_q[addr_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && !we_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pwb_post_buffer.sv
module pwb_post_buffer #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [NB-1:0]     wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic              valid_o,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_addr_o,
  output logic [NB-1:0]     commit_be_o,
  output logic [DATA_W-1:0] data_o,
  output logic [NB-1:0]     hit_be_o
);
  logic              valid_q;
  logic [IDX_W-1:0]  addr_q;
  logic [NB-1:0]     be_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      data_q  <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      addr_q  <= waddr_i;
      be_q    <= wbe_i;
      data_q  <= wdata_i;
    end
  end

  assign valid_o       = valid_q;
  assign commit_o      = wr_i && valid_q;
  assign commit_addr_o = addr_q;
  assign commit_be_o   = be_q;
  assign data_o        = data_q;
  assign hit_be_o      = (valid_q && (raddr_i == addr_q)) ? be_q : '0;
endmodule

// File: rtl/pwb_sram_ctrl.sv
module pwb_sram_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB),
  localparam int IDX_W = ADDR_W - OFF_W,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              ready_q;
  logic              wr_acc, rd_acc;
  logic [IDX_W-1:0]  word_idx;
  logic [NB-1:0]     req_be;

  logic              buf_valid, commit_en;
  logic [IDX_W-1:0]  commit_addr;
  logic [NB-1:0]     commit_be, hit_be;
  logic [DATA_W-1:0] buf_data;

  logic              mem_en, mem_we;
  logic [IDX_W-1:0]  mem_addr;
  logic [DATA_W-1:0] mem_rdata;

  logic              rvalid_q;
  logic [NB-1:0]     fwd_be_q;
  logic [DATA_W-1:0] fwd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign ready_o  = ready_q;
  assign wr_acc   = req_i && ready_q && we_i;
  assign rd_acc   = req_i && ready_q && !we_i;
  assign word_idx = addr_i[ADDR_W-1:OFF_W];

  pwb_lane_decode #(.NB(NB)) u_lanes (
    .off_i  (addr_i[OFF_W-1:0]),
    .size_i (size_i),
    .be_o   (req_be)
  );

  pwb_post_buffer #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_acc),
    .waddr_i       (word_idx),
    .wbe_i         (req_be),
    .wdata_i       (wdata_i),
    .raddr_i       (word_idx),
    .valid_o       (buf_valid),
    .commit_o      (commit_en),
    .commit_addr_o (commit_addr),
    .commit_be_o   (commit_be),
    .data_o        (buf_data),
    .hit_be_o      (hit_be)
  );

  // single port: a write cycle owns it for the commit, a read cycle for the lookup
  always_comb begin
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = word_idx;
    if (wr_acc) begin
      mem_en   = commit_en;
      mem_we   = 1'b1;
      mem_addr = commit_addr;
    end else if (rd_acc) begin
      mem_en   = 1'b1;
    end
  end

  pwb_sram_model #(.WORDS(WORDS), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .be_i    (commit_be),
    .addr_i  (mem_addr),
    .wdata_i (buf_data),
    .rdata_o (mem_rdata)
  );

  // forwarding snapshot taken when the read is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q   <= 1'b0;
      fwd_be_q   <= '0;
      fwd_data_q <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) begin
        fwd_be_q   <= hit_be;
        fwd_data_q <= buf_data;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign rdata_o[8*b +: 8] = fwd_be_q[b] ? fwd_data_q[8*b +: 8] : mem_rdata[8*b +: 8];
  end

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/pwb_sram_ctrl_chk.sv
module pwb_sram_ctrl_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic          buf_valid,
  input logic          commit_en,
  input logic [NB-1:0] commit_be
);
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R7

  AST_READ_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && ready_o) |=> rvalid_o); // R10

  AST_RVALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i && ready_o)); // R10

  AST_COMMIT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en |-> (req_i && we_i && ready_o)); // R4

  AST_WRITE_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ready_o) |=> buf_valid); // R3

  AST_COMMIT_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en |-> (commit_be != '0)); // R9
endmodule

bind pwb_sram_ctrl pwb_sram_ctrl_chk #(.NB(NB)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .ready_o   (ready_o),
  .rvalid_o  (rvalid_o),
  .buf_valid (buf_valid),
  .commit_en (commit_en),
  .commit_be (commit_be)
);

// File: tb/pwb_sram_ctrl_test.sv
`timescale 1ns/1ps
module pwb_sram_ctrl_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [1:0]        size_i = 2'd0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              ready_o, rvalid_o;
  logic [DATA_W-1:0] rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] rmem [0:1023];
  bit          rb_v = 0;
  logic [9:0]  rb_w;
  logic [3:0]  rb_be;
  logic [31:0] rb_d;

  pwb_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [3:0] ref_lanes(input logic [11:0] a, input logic [1:0] s);
    case (s)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] ref_merge(input logic [31:0] base, input logic [31:0] d,
                                            input logic [3:0] be);
    logic [31:0] r = base;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // each op drives just after a negedge and returns at the next negedge
  task automatic do_write(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    chk(ready_o === 1'b1, "R7 no stall", {31'b0, ready_o}, 32'd1);
    req_i = 1; we_i = 1; addr_i = a; size_i = s; wdata_i = d;
    if (rb_v) rmem[rb_w] = ref_merge(rmem[rb_w], rb_d, rb_be);
    rb_v = 1; rb_w = a[11:2]; rb_be = ref_lanes(a, s); rb_d = d;
    @(negedge clk_i);
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    logic [31:0] exp;
    exp = rmem[a[11:2]];
    if (rb_v && rb_w == a[11:2]) exp = ref_merge(exp, rb_d, rb_be);
    req_i = 1; we_i = 0; addr_i = a; size_i = 2'd2;
    @(negedge clk_i);
    chk(rvalid_o === 1'b1, "R10 rvalid", {31'b0, rvalid_o}, 32'd1);
    chk(rdata_o === exp, req, rdata_o, exp);
  endtask

  task automatic idle();
    req_i = 0; we_i = 0;
    @(negedge clk_i);
    chk(rvalid_o === 1'b0, "R10 idle rvalid", {31'b0, rvalid_o}, 32'd0);
  endtask

  task automatic do_reset();
    req_i = 0; rst_ni = 0;
    #1;
    chk(ready_o === 1'b0, "R7 ready in reset", {31'b0, ready_o}, 32'd0);
    chk(rvalid_o === 1'b0, "R10 rvalid in reset", {31'b0, rvalid_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1; rb_v = 0;
    @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk_i);
    do_reset();
    // prefill words 0..63, then dummy to word 64
    for (int w = 0; w < 64; w++) do_write(12'(w * 4), 2'd2, $urandom());
    do_write(12'd256, 2'd2, 32'hdead_0040);
    // R3 R5: parked write lost on reset
    do_write(12'h014, 2'd2, 32'haaaa_5555);
    do_reset();
    do_read(12'h014, "R5 reset drops parked write");
    // R6: doubled write survives
    do_write(12'h018, 2'd2, 32'h1234_5678);
    do_write(12'h018, 2'd2, 32'h1234_5678);
    do_reset();
    do_read(12'h018, "R6 double write persists");
    // R4: dummy write flushes
    do_write(12'h01c, 2'd2, 32'hcafe_f00d);
    do_write(12'd256, 2'd2, 32'h0);
    do_reset();
    do_read(12'h01c, "R4 dummy write commits");
    // R9 R1: byte commit only touches its lane
    do_write(12'h021, 2'd0, 32'h0000_ab00);
    do_write(12'd256, 2'd2, 32'h0);
    do_reset();
    do_read(12'h020, "R9 partial commit lanes");
    // R2: misaligned halfword and word
    do_write(12'h027, 2'd1, 32'hbeef_0000);
    do_read(12'h024, "R2 halfword alignment fwd");
    do_write(12'h02b, 2'd3, 32'h7777_8888);
    do_write(12'd256, 2'd2, 32'h0);
    do_read(12'h024, "R2 halfword alignment array");
    do_read(12'h028, "R2 R1 word alignment size3");
    // R8: forwarding and snapshot timing
    do_write(12'h02a, 2'd0, 32'h0033_0000);
    do_read(12'h028, "R8 forward merge");
    do_write(12'h028, 2'd1, 32'h0000_9999);
    do_read(12'h028, "R8 forward after replace");
    do_read(12'h028, "R8 read before write snapshot");
    do_write(12'h028, 2'd2, 32'h5151_5151);
    idle();
    do_read(12'h028, "R8 after back-to-back");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a = 12'($urandom_range(0, 255));
      if ($urandom_range(0, 99) < 55)
        do_write(a, 2'($urandom_range(0, 3)), $urandom());
      else
        do_read(a, "R8 R1 random read");
      if ($urandom_range(0, 99) < 5) idle();
      if ($urandom_range(0, 199) == 0) begin
        do_reset();
        do_read(a, "R5 random reset");
      end
    end
    idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule